// File: doc/BRIEF.md
# Fractional pixel clock divider

The block derives a display pixel clock from a faster source clock. The period is given in source-clock cycles as an 8-bit integer with a 4-bit binary fraction, in sixteenths of a cycle. The fraction is accumulated from period to period, so the average period matches the programmed value. Each single period still spans a whole number of source cycles.

Within each period, the rising and falling edges of the output are placed independently. Their positions are in half-source-cycle slots counted from the period start, so the duty cycle is programmable. A polarity input gives a second output that is the pixel clock, optionally inverted. A new divider or edge setting is taken up only where one period ends and the next begins.

Top module: `frac_pix_clkdiv`

## Requirements
- R1: While reset is asserted, both clock outputs are driven to the level they would have with the internal clock held low (pix_clk_o = 0, disp_clk_o = pol_inv_i). Reset is released through two synchronizing flops. The first period starts at the third rising source edge after release and uses the configuration present at that edge.
- R2: div_cfg_i[11:4] is the integer period in source cycles and div_cfg_i[3:0] is the fraction in sixteenths. An integer field of 0 is treated as 1, and 255 is the longest integer period.
- R3: Each period adds the fraction to a 4-bit accumulator that starts at zero after reset. A carry out of the accumulator lengthens that period by one source cycle. Over any run of periods, the total length is the sum of the integer parts plus the whole part of the accumulated fractions.
- R4: Slot h of a period covers the high half (even h) or the low half (odd h) of source cycle h/2. rise_pos_i and fall_pos_i give slot numbers R and F. If R < F, the output is high for R <= h < F. If R > F, it is high for h >= R or h < F. If R == F, it is low for the whole period.
- R5: An edge position at or beyond twice the period length, in slots, is clamped to the last slot of that period.
- R6: With R = 0 and F equal to the integer divider, and no fraction, the output is high for exactly the first half of each period.
- R7: A change on div_cfg_i, rise_pos_i or fall_pos_i in the middle of a period does not alter the current period. It takes effect at the next period start.
- R8: disp_clk_o equals pix_clk_o when pol_inv_i is 0 and its inverse when pol_inv_i is 1, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_cfg_i | input | 12 | Period: integer in bits 11:4, fraction in bits 3:0 |
| rise_pos_i | input | 9 | Rising-edge slot, in half source cycles |
| fall_pos_i | input | 9 | Falling-edge slot, in half source cycles |
| pol_inv_i | input | 1 | Inverts disp_clk_o when set |
| pix_clk_o | output | 1 | Divided pixel clock |
| disp_clk_o | output | 1 | Pixel clock after the polarity selection |

## Verification
A wrong slot counter or wrong latched edge shows up as a wrong output level in the very half-cycle concerned. For this reason, the bench compares both halves of every source cycle against its own period model. A bad fraction accumulator moves a period boundary by one source cycle. Such a shift becomes visible within at most sixteen periods, and every following edge then lands in the wrong slot. A configuration taken up mid-period shows as an edge out of place inside the period where the change was made.

// File: rtl/fpcd_pkg.sv
`timescale 1ns/1ps
package fpcd_pkg;
  // default field widths of the divider configuration
  localparam int unsigned INT_W_DEF  = 8;
  localparam int unsigned FRAC_W_DEF = 4;
  localparam int unsigned EDGE_W_DEF = 9;
endpackage

// File: rtl/pcd_period_seq.sv
`timescale 1ns/1ps
module pcd_period_seq #(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned EDGE_W = 9,
  localparam int unsigned LEN_W  = INT_W + 1,
  localparam int unsigned SLOT_W = INT_W + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [INT_W+FRAC_W-1:0]   div_cfg_i,
  input  logic [EDGE_W-1:0]         rise_i,
  input  logic [EDGE_W-1:0]         fall_i,
  output logic [LEN_W-1:0]          cnt_nx_o,
  output logic [SLOT_W-1:0]         rise_nx_o,
  output logic [SLOT_W-1:0]         fall_nx_o
);
  logic [LEN_W-1:0]  cnt_q, cnt_d, len_q, len_d, len_nx;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [SLOT_W-1:0] rise_q, rise_d, fall_q, fall_d, lim_nx, rise_w, fall_w;
  logic [INT_W-1:0]  int_raw, int_eff;
  logic [FRAC_W:0]   frac_sum;
  logic              wrap_w, cfg_en;

  // next-period parameters from the live configuration
  always_comb begin
    int_raw  = div_cfg_i[INT_W+FRAC_W-1:FRAC_W];
    int_eff  = (int_raw == '0) ? INT_W'(1) : int_raw;
    frac_sum = {1'b0, acc_q} + {1'b0, div_cfg_i[FRAC_W-1:0]};
    len_nx   = {1'b0, int_eff} + LEN_W'(frac_sum[FRAC_W]);
    lim_nx   = {len_nx, 1'b0} - SLOT_W'(1);
    rise_w   = SLOT_W'(rise_i);
    fall_w   = SLOT_W'(fall_i);
    wrap_w   = (cnt_q == len_q - LEN_W'(1));
    cfg_en   = wrap_w;
  end

  always_comb begin
    cnt_d  = cnt_q + LEN_W'(1);
    len_d  = len_q;
    acc_d  = acc_q;
    rise_d = rise_q;
    fall_d = fall_q;
    if (wrap_w) begin
      cnt_d  = '0;
      len_d  = len_nx;
      acc_d  = frac_sum[FRAC_W-1:0];
      rise_d = (rise_w > lim_nx) ? lim_nx : rise_w;
      fall_d = (fall_w > lim_nx) ? lim_nx : fall_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // configuration state, enabled only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= LEN_W'(1);
      acc_q  <= '0;
      rise_q <= '0;
      fall_q <= SLOT_W'(1);
    end else if (cfg_en) begin
      len_q  <= len_d;
      acc_q  <= acc_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign cnt_nx_o  = cnt_d;
  assign rise_nx_o = rise_d;
  assign fall_nx_o = fall_d;

  // R3: slot counter stays inside the current period
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_q);
  // R2: new period is the integer part, possibly plus one carry cycle
  p_len_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_w |=> (len_q >= LEN_W'($past(int_eff))) &&
               (len_q <= LEN_W'($past(int_eff)) + LEN_W'(1)));
  // R5: latched edges never fall outside the period
  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_q < {len_q, 1'b0}) && (fall_q < {len_q, 1'b0}));
  // R7: configuration is frozen inside a period
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_w |=> $stable(len_q) && $stable(acc_q) && $stable(rise_q) && $stable(fall_q));
endmodule

// File: rtl/pcd_wave_shaper.sv
`timescale 1ns/1ps
module pcd_wave_shaper #(
  parameter int unsigned LEN_W  = 9,
  localparam int unsigned SLOT_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  cnt_nx_i,
  input  logic [SLOT_W-1:0] rise_nx_i,
  input  logic [SLOT_W-1:0] fall_nx_i,
  output logic              hi_phase_o,
  output logic              lo_phase_o
);
  logic hi_q, lo_q, hi_d, lo_d;

  function automatic logic slot_on(input logic [SLOT_W-1:0] h,
                                   input logic [SLOT_W-1:0] r,
                                   input logic [SLOT_W-1:0] f);
    if (r == f)     return 1'b0;
    else if (r < f) return (h >= r) && (h < f);
    else            return (h >= r) || (h < f);
  endfunction

  // level of both half-slots of the coming source cycle
  always_comb begin
    hi_d = slot_on({cnt_nx_i, 1'b0}, rise_nx_i, fall_nx_i);
    lo_d = slot_on({cnt_nx_i, 1'b1}, rise_nx_i, fall_nx_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_phase_o = hi_q;
  assign lo_phase_o = lo_q;

  // R4: coincident edges hold the output low
  p_equal_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_nx_i == fall_nx_i) |=> !hi_q && !lo_q);
  // R4: a rise at slot zero makes the first half of a period high unless edges coincide
  p_first_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_nx_i == '0 && rise_nx_i == '0 && fall_nx_i != '0) |=> hi_q);
endmodule

// File: rtl/pcd_clk_out.sv
`timescale 1ns/1ps
module pcd_clk_out (
  input  logic clk_i,
  input  logic hi_phase_i,
  input  logic lo_phase_i,
  input  logic pol_inv_i,
  output logic pix_clk_o,
  output logic disp_clk_o
);
  logic pix_w;

  // the source clock steers between the two registered half-slot levels
  always_comb begin
    pix_w      = clk_i ? hi_phase_i : lo_phase_i;
    pix_clk_o  = pix_w;
    disp_clk_o = pix_w ^ pol_inv_i;
  end
endmodule

// File: rtl/frac_pix_clkdiv.sv
`timescale 1ns/1ps
module frac_pix_clkdiv
  import fpcd_pkg::*;
#(
  parameter int unsigned INT_W  = INT_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned EDGE_W = EDGE_W_DEF,
  localparam int unsigned LEN_W  = INT_W + 1,
  localparam int unsigned SLOT_W = INT_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [INT_W+FRAC_W-1:0] div_cfg_i,
  input  logic [EDGE_W-1:0]       rise_pos_i,
  input  logic [EDGE_W-1:0]       fall_pos_i,
  input  logic                    pol_inv_i,
  output logic                    pix_clk_o,
  output logic                    disp_clk_o
);
  logic              rst_meta_q, rst_sync_q;
  logic [LEN_W-1:0]  cnt_nx;
  logic [SLOT_W-1:0] rise_nx, fall_nx;
  logic              hi_phase, lo_phase;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pcd_period_seq #(.INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .div_cfg_i (div_cfg_i),
    .rise_i    (rise_pos_i),
    .fall_i    (fall_pos_i),
    .cnt_nx_o  (cnt_nx),
    .rise_nx_o (rise_nx),
    .fall_nx_o (fall_nx)
  );

  pcd_wave_shaper #(.LEN_W(LEN_W)) u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .cnt_nx_i   (cnt_nx),
    .rise_nx_i  (rise_nx),
    .fall_nx_i  (fall_nx),
    .hi_phase_o (hi_phase),
    .lo_phase_o (lo_phase)
  );

  pcd_clk_out u_out (
    .clk_i      (clk_i),
    .hi_phase_i (hi_phase),
    .lo_phase_i (lo_phase),
    .pol_inv_i  (pol_inv_i),
    .pix_clk_o  (pix_clk_o),
    .disp_clk_o (disp_clk_o)
  );

  // R1: output stays low while the internal reset is held
  p_rst_quiet_r1: assert property (@(posedge clk_i)
    !rst_sync_q |=> !hi_phase || rst_sync_q);
endmodule

// File: tb/frac_pix_clkdiv_tb.sv
`timescale 1ns/1ps
module frac_pix_clkdiv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] div;
  logic [8:0]  rpos, fpos;
  logic        pol;
  logic        pix, disp;

  int    checks, fails;
  string req;
  bit    done;
  int    m_tot, m_len, m_idx, m_left, m_rise, m_fall;

  always #2 clk = ~clk;

  frac_pix_clkdiv dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_cfg_i(div), .rise_pos_i(rpos),
    .fall_pos_i(fpos), .pol_inv_i(pol), .pix_clk_o(pix), .disp_clk_o(disp)
  );

  function automatic bit exp_slot(int h, int r, int f);
    if (r == f) return 1'b0;
    if (r < f)  return (h >= r && h < f);
    return !(h >= f && h < r);
  endfunction

  task automatic chk(bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // a new period: length from the running sum of sixteenths (R2, R3), clamped edges (R5)
  task automatic model_start();
    int ie, old, lim;
    ie = int'(div[11:4]);
    if (ie == 0) ie = 1;
    old    = m_tot >> 4;
    m_tot  = m_tot + ie * 16 + int'(div[3:0]);
    m_len  = (m_tot >> 4) - old;
    lim    = 2 * m_len - 1;
    m_rise = (int'(rpos) > lim) ? lim : int'(rpos);
    m_fall = (int'(fpos) > lim) ? lim : int'(fpos);
    m_idx  = 0;
    m_left = m_len;
  endtask

  task automatic run(int n);
    bit ea, eb;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (m_left == 0) model_start();
      ea = exp_slot(2 * m_idx, m_rise, m_fall);
      eb = exp_slot(2 * m_idx + 1, m_rise, m_fall);
      m_idx++;
      m_left--;
      #1;
      chk(pix, ea, "pix high half");
      chk(disp, ea ^ pol, "disp high half");
      @(negedge clk);
      #1;
      chk(pix, eb, "pix low half");
      chk(disp, eb ^ pol, "disp low half");
    end
  endtask

  task automatic set_cfg(logic [11:0] d, int r, int f);
    div  = d;
    rpos = 9'(r);
    fpos = 9'(f);
  endtask

  initial begin
    checks = 0; fails = 0; done = 0; req = "R1";
    m_tot = 0; m_len = 0; m_idx = 0; m_left = 0; m_rise = 0; m_fall = 0;
    rst_n = 1'b0; pol = 1'b0;
    set_cfg(12'h010, 0, 1);
    void'($urandom(32'd7421));
    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk); #1;
      chk(pix, 1'b0, "pix in reset");
      chk(disp, 1'b0, "disp in reset");
    end
    req = "R8";
    pol = 1'b1; #1;
    chk(disp, 1'b1, "disp inverted in reset");
    pol = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    repeat (2) begin
      @(posedge clk); #1; chk(pix, 1'b0, "pix before first period");
      @(negedge clk); #1; chk(pix, 1'b0, "pix before first period");
    end
    run(4);
    req = "R6"; set_cfg(12'h040, 0, 4); run(16);
    req = "R3"; set_cfg(12'h028, 0, 2); run(48);
    set_cfg(12'h013, 0, 1); run(60);
    req = "R2"; set_cfg(12'h000, 0, 1); run(8);
    set_cfg(12'h008, 0, 1); run(12);
    set_cfg(12'hFF0, 0, 255); run(520);
    req = "R5"; set_cfg(12'h030, 2, 300); run(20);
    set_cfg(12'h030, 400, 1); run(20);
    req = "R4"; set_cfg(12'h040, 5, 2); run(16);
    set_cfg(12'h040, 3, 3); run(12);
    req = "R7"; set_cfg(12'h0A0, 0, 10); run(15);
    set_cfg(12'h020, 0, 2); run(3);
    set_cfg(12'h050, 1, 7); run(23);
    req = "R8"; pol = 1'b1; set_cfg(12'h030, 0, 3); run(12);
    pol = 1'b0; run(6);
    req = "R4";
    for (int k = 0; k < 60; k++) begin
      set_cfg({8'(1 + $urandom % 24), 4'($urandom)}, int'($urandom % 64), int'($urandom % 64));
      pol = 1'($urandom);
      run(5 + int'($urandom % 50));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule